// File: doc/BRIEF.md
# Adaptive-Gain Bang-Bang Clock Recovery Loop

This block is the digital control path of a first-order clock-recovery loop. It takes early and late decisions from a bang-bang phase detector and produces the code for a phase interpolator. It also adjusts its own loop gain from the recent history of the loop's corrections.

The decisions first enter a truncating pre-filter. This is a small signed accumulator. It emits an up or down carry when its sum reaches a threshold, which is selectable as 1, 2, 4 or 8, and it clears itself when it emits. Each carry is scaled by the current gain of 1, 2 or 4. The scaled step travels through a short pipeline that models the loop latency, and then it is added into a wrapping phase accumulator.

An adaptation unit sums the carries over fixed windows of N cycles. At the end of each window it compares the magnitude of the sum against a lower and an upper threshold. A large magnitude means the loop is slewing, so the gain doubles. A small magnitude means the loop is settled, so the gain halves. Anything in between leaves the gain unchanged.

Top module: `cdr_adapt_loop`

## Requirements
- R1: While `rst_n` is low, `phase_code` reads 0 and `gain_sel` reads 2 (gain 4). After `rst_n` rises, the loop stays in reset for two further clock edges and starts operating on the third.
- R2: Error encoding: `late` alone is +1 and `early` alone is −1. When both are high or both are low the error is 0, and neither the pre-filter nor the phase changes.
- R3: The pre-filter adds the error to its sum. When the new sum is at least +2^`thr_sel` it emits an up carry, and when it is at most −2^`thr_sel` it emits a down carry. In both cases the sum is cleared to 0 and the remainder is not kept.
- R4: Gain code `gain_sel` values 0, 1 and 2 mean gains 1, 2 and 4. Each carry moves the phase by +gain (up carry) or −gain (down carry), using the gain code present on the edge after the carry is registered.
- R5: A decision sampled on clock edge k changes `phase_code` just after edge k+4. The loop delay is five edges.
- R6: `phase_code` wraps modulo 2^PH_W (default 7 bits).
- R7: The adaptation window is WIN_LEN cycles (default 32) and starts at reset release. It sums the registered carries, evaluates on the last cycle of the window, and restarts from zero.
- R8: A window magnitude strictly above `hi_th` doubles the gain. A magnitude strictly below `lo_th` halves it. Any other magnitude holds it.
- R9: Doubling at gain 4 and halving at gain 1 leave the gain unchanged.
- R10: The gain changes only at window ends, and by at most one code step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| early | input | 1 | Detector reports the sampling clock is early |
| late | input | 1 | Detector reports the sampling clock is late |
| thr_sel | input | 2 | Pre-filter threshold select, threshold 2^thr_sel |
| lo_th | input | $clog2(WIN_LEN)+1 | Window magnitude below which gain halves |
| hi_th | input | $clog2(WIN_LEN)+1 | Window magnitude above which gain doubles |
| phase_code | output | PH_W | Phase interpolator code |
| gain_sel | output | 2 | Current gain code (0/1/2 for 1/2/4) |

## Verification
The bench checks the exact five-edge latency with isolated single decisions. A pipeline that is one stage short or long would move the phase a cycle early or late. It also checks that the pre-filter residue is cleared on carry. A filter that kept its sum would keep emitting carries and overshoot the expected two steps of the divide-by-eight test. Long quiet and long slewing runs push the gain into both limits, so a design that fails to saturate would wrap the gain code. A run with the thresholds opened wide proves that the gain holds between them. Random traffic with changing thresholds is compared cycle by cycle against a model, and this exposes a window that is misaligned, not cleared, or applies its gain on the wrong edge.

// File: rtl/cdr_adapt_pkg.sv
package cdr_adapt_pkg;

  localparam int GAIN_SEL_W = 2;
  localparam logic [GAIN_SEL_W-1:0] GAIN_TOP = 2'd2;
  localparam int STEP_W = 4;

  typedef logic [GAIN_SEL_W-1:0] gain_sel_t;
  typedef logic signed [STEP_W-1:0] step_t;

  typedef struct packed {
    logic up;
    logic dn;
  } carry_t;

  // Signed phase step for one carry at the given gain code
  function automatic step_t scale_carry(carry_t c, gain_sel_t g);
    step_t mag;
    case (g)
      2'd0:    mag = 4'sd1;
      2'd1:    mag = 4'sd2;
      default: mag = 4'sd4;
    endcase
    if (c.up)      scale_carry = mag;
    else if (c.dn) scale_carry = -mag;
    else           scale_carry = '0;
  endfunction

endpackage

// File: rtl/cdr_prefilter.sv
module cdr_prefilter
  import cdr_adapt_pkg::*;
#(
  parameter int ACC_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    early,
  input  logic                    late,
  input  logic [1:0]              thr_sel,
  output carry_t                  carry_o,
  output logic signed [ACC_W-1:0] acc_o
);

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] err, sum, thr;
  carry_t carry_q, carry_d;

  always_comb begin
    case ({late, early})
      2'b10:   err = ACC_W'(1);
      2'b01:   err = {ACC_W{1'b1}};
      default: err = '0;
    endcase
    sum     = acc_q + err;
    thr     = ACC_W'(1) <<< thr_sel;
    carry_d = '0;
    acc_d   = sum;
    if (sum >= thr) begin
      carry_d.up = 1'b1;
      acc_d      = '0;
    end else if (sum <= -thr) begin
      carry_d.dn = 1'b1;
      acc_d      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= '0;
    end else begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  assign carry_o = carry_q;
  assign acc_o   = acc_q;

endmodule

// File: rtl/cdr_gain_adapt.sv
module cdr_gain_adapt
  import cdr_adapt_pkg::*;
#(
  parameter int WIN_LEN = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  carry_t                     carry_i,
  input  logic [$clog2(WIN_LEN):0]   lo_th,
  input  logic [$clog2(WIN_LEN):0]   hi_th,
  output gain_sel_t                  gain_o
);

  localparam int CNT_W = $clog2(WIN_LEN);
  localparam int TH_W  = CNT_W + 1;
  localparam int WS_W  = TH_W + 1;

  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic signed [WS_W-1:0] wsum_q, wsum_d;
  logic signed [WS_W-1:0] cval, total;
  logic [WS_W-1:0]        mag;
  logic                   win_last;
  gain_sel_t              gain_q, gain_d;

  always_comb begin
    if (carry_i.up)      cval = WS_W'(1);
    else if (carry_i.dn) cval = {WS_W{1'b1}};
    else                 cval = '0;
    total    = wsum_q + cval;
    mag      = total[WS_W-1] ? WS_W'(-total) : WS_W'(total);
    win_last = (cnt_q == CNT_W'(WIN_LEN - 1));
    gain_d   = gain_q;
    if (win_last) begin
      cnt_d  = '0;
      wsum_d = '0;
      if (mag > {1'b0, hi_th}) begin
        if (gain_q != GAIN_TOP) gain_d = gain_q + 1'b1;
      end else if (mag < {1'b0, lo_th}) begin
        if (gain_q != '0) gain_d = gain_q - 1'b1;
      end
    end else begin
      cnt_d  = cnt_q + 1'b1;
      wsum_d = total;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wsum_q <= '0;
      gain_q <= GAIN_TOP;
    end else begin
      cnt_q  <= cnt_d;
      wsum_q <= wsum_d;
      gain_q <= gain_d;
    end
  end

  assign gain_o = gain_q;

endmodule

// File: rtl/cdr_phase_path.sv
module cdr_phase_path
  import cdr_adapt_pkg::*;
#(
  parameter int PH_W     = 7,
  parameter int LOOP_DLY = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  carry_t          carry_i,
  input  gain_sel_t       gain_i,
  output logic [PH_W-1:0] phase_o
);

  // One edge in the pre-filter and one in the phase register; the rest here
  localparam int PIPE_N = LOOP_DLY - 2;

  logic [PH_W-1:0] phase_q, phase_d;
  step_t           step;

  for (genvar i = 0; i < PIPE_N; i++) begin : g_dly
    step_t q, d;
    if (i == 0) begin : g_head
      assign d = scale_carry(carry_i, gain_i);
    end else begin : g_tail
      assign d = g_dly[i-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign step = g_dly[PIPE_N-1].q;

  always_comb begin
    phase_d = phase_q + PH_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/cdr_adapt_loop.sv
module cdr_adapt_loop
  import cdr_adapt_pkg::*;
#(
  parameter int PH_W      = 7,
  parameter int WIN_LEN   = 32,
  parameter int LOOP_DLY  = 5,
  parameter int PF_ACC_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      early,
  input  logic                      late,
  input  logic [1:0]                thr_sel,
  input  logic [$clog2(WIN_LEN):0]  lo_th,
  input  logic [$clog2(WIN_LEN):0]  hi_th,
  output logic [PH_W-1:0]           phase_code,
  output logic [1:0]                gain_sel
);

  logic [1:0]                 rsync_q;
  logic                       rst_sync_n;
  carry_t                     pf_carry;
  logic                       pf_up, pf_dn;
  logic signed [PF_ACC_W-1:0] pf_acc;
  gain_sel_t                  gain;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  cdr_prefilter #(.ACC_W(PF_ACC_W)) u_pf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .early   (early),
    .late    (late),
    .thr_sel (thr_sel),
    .carry_o (pf_carry),
    .acc_o   (pf_acc)
  );

  assign pf_up = pf_carry.up;
  assign pf_dn = pf_carry.dn;

  cdr_gain_adapt #(.WIN_LEN(WIN_LEN)) u_adapt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .carry_i (pf_carry),
    .lo_th   (lo_th),
    .hi_th   (hi_th),
    .gain_o  (gain)
  );

  cdr_phase_path #(.PH_W(PH_W), .LOOP_DLY(LOOP_DLY)) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .carry_i (pf_carry),
    .gain_i  (gain),
    .phase_o (phase_code)
  );

  assign gain_sel = gain;

endmodule

// File: rtl/cdr_adapt_loop_chk.sv
module cdr_adapt_loop_chk #(
  parameter int PH_W    = 7,
  parameter int WIN_LEN = 32,
  parameter int ACC_W   = 5
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    early,
  input logic                    late,
  input logic [1:0]              thr_sel,
  input logic                    carry_up,
  input logic                    carry_dn,
  input logic signed [ACC_W-1:0] pf_acc,
  input logic [1:0]              gain_sel,
  input logic [PH_W-1:0]         phase_code
);

  localparam int CNT_W = $clog2(WIN_LEN);
  localparam logic [PH_W-1:0] PH_LO = PH_W'(4);
  localparam logic [PH_W-1:0] PH_HI = PH_W'((1 << PH_W) - 4);

  logic [CNT_W-1:0] win_cnt;

  // Independent window position tracker
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) win_cnt <= '0;
    else if (win_cnt == CNT_W'(WIN_LEN - 1)) win_cnt <= '0;
    else win_cnt <= win_cnt + 1'b1;
  end

  a_r3_carry_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(carry_up && carry_dn));

  a_r2_idle_no_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (early == late) && (thr_sel == $past(thr_sel)) |=>
      (!carry_up && !carry_dn && $stable(pf_acc)));

  a_r9_gain_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gain_sel <= 2'd2);

  a_r10_gain_only_at_window_end: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_cnt != CNT_W'(WIN_LEN - 1)) |=> $stable(gain_sel));

  a_r10_gain_single_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (({1'b0, gain_sel} <= {1'b0, $past(gain_sel)} + 3'd1) &&
              ({1'b0, $past(gain_sel)} <= {1'b0, gain_sel} + 3'd1)));

  a_r4_phase_step_bounded: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((PH_W'(phase_code - $past(phase_code)) <= PH_LO) ||
              (PH_W'(phase_code - $past(phase_code)) >= PH_HI)));

endmodule

bind cdr_adapt_loop cdr_adapt_loop_chk #(
  .PH_W    (PH_W),
  .WIN_LEN (WIN_LEN),
  .ACC_W   (PF_ACC_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .early      (early),
  .late       (late),
  .thr_sel    (thr_sel),
  .carry_up   (pf_up),
  .carry_dn   (pf_dn),
  .pf_acc     (pf_acc),
  .gain_sel   (gain_sel),
  .phase_code (phase_code)
);

// File: tb/cdr_adapt_loop_test.sv
module cdr_adapt_loop_test;

  localparam int CLK_PERIOD = 10;
  localparam int PH_W = 7;
  localparam int WIN = 32;
  localparam int TH_W = 6;
  localparam int PH_MOD = 1 << PH_W;

  logic clk = 1'b0;
  logic rst_n, early, late;
  logic [1:0] thr_sel;
  logic [TH_W-1:0] lo_th, hi_th;
  logic [PH_W-1:0] phase_code;
  logic [1:0] gain_sel;

  int n_vec = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdr_adapt_loop uut (
    .clk(clk), .rst_n(rst_n), .early(early), .late(late), .thr_sel(thr_sel),
    .lo_th(lo_th), .hi_th(hi_th), .phase_code(phase_code), .gain_sel(gain_sel)
  );

  // Behavioural model built from the requirements
  int m_acc, m_carry, m_p0, m_p1, m_p2, m_phase, m_gain, m_cnt, m_wsum, m_rs;
  int e, s, t, tot, mag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= 0; m_carry <= 0; m_p0 <= 0; m_p1 <= 0; m_p2 <= 0;
      m_phase <= 0; m_gain <= 2; m_cnt <= 0; m_wsum <= 0; m_rs <= 0;
    end else if (m_rs < 2) begin
      m_rs <= m_rs + 1;
    end else begin
      e = (late && !early) ? 1 : ((early && !late) ? -1 : 0);
      s = m_acc + e;
      t = 1 << thr_sel;
      if (s >= t)       begin m_carry <= 1;  m_acc <= 0; end
      else if (s <= -t) begin m_carry <= -1; m_acc <= 0; end
      else              begin m_carry <= 0;  m_acc <= s; end
      m_p0 <= m_carry * (1 << m_gain);
      m_p1 <= m_p0;
      m_p2 <= m_p1;
      m_phase <= ((m_phase + m_p2) % PH_MOD + PH_MOD) % PH_MOD;
      if (m_cnt == WIN - 1) begin
        tot = m_wsum + m_carry;
        mag = (tot < 0) ? -tot : tot;
        if (mag > int'(hi_th)) begin
          if (m_gain < 2) m_gain <= m_gain + 1;
        end else if (mag < int'(lo_th)) begin
          if (m_gain > 0) m_gain <= m_gain - 1;
        end
        m_wsum <= 0;
        m_cnt <= 0;
      end else begin
        m_wsum <= m_wsum + m_carry;
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one decision, wait one edge, compare with the model
  task automatic tick(input logic e_i, input logic l_i);
    early = e_i;
    late = l_i;
    @(negedge clk);
    chk("R4 R5 R6 phase vs model", int'(phase_code), m_phase);
    chk("R7 R8 R9 R10 gain vs model", int'(gain_sel), m_gain);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int p0, r, bias;
    void'($urandom(32'd20061));
    rst_n = 1'b0; early = 1'b0; late = 1'b0; thr_sel = 2'd0;
    lo_th = 6'd4; hi_th = 6'd12;
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", int'(phase_code), 0);
    chk("R1 gain in reset", int'(gain_sel), 2);
    rst_n = 1'b1;
    repeat (3) tick(0, 0);
    chk("R1 phase after release", int'(phase_code), 0);
    chk("R1 gain after release", int'(gain_sel), 2);

    // R5: single late decision, gain 4, threshold 1
    tick(0, 1);
    repeat (3) tick(0, 0);
    chk("R5 phase before delay elapses", int'(phase_code), 0);
    tick(0, 0);
    chk("R5 R2 late gives +gain after five edges", int'(phase_code), 4);

    // R2: early alone steps back
    tick(1, 0);
    repeat (5) tick(0, 0);
    chk("R2 early gives -gain", int'(phase_code), 0);

    // R2: both asserted is no error
    repeat (10) tick(1, 1);
    repeat (5) tick(0, 0);
    chk("R2 both asserted no move", int'(phase_code), 0);

    // R8 R9: quiet windows walk gain to the floor
    repeat (96) tick(0, 0);
    chk("R8 R9 quiet halves to floor", int'(gain_sel), 0);

    // R3: divide by eight, residue cleared
    thr_sel = 2'd3;
    p0 = int'(phase_code);
    repeat (16) tick(0, 1);
    repeat (12) tick(0, 0);
    chk("R3 sixteen late at threshold 8", int'(phase_code), (p0 + 2) % PH_MOD);
    chk("R9 gain stays at floor", int'(gain_sel), 0);

    // R8 R9 R6: slewing doubles to the ceiling and wraps the code
    thr_sel = 2'd0;
    repeat (100) tick(0, 1);
    chk("R8 R9 slewing doubles to ceiling", int'(gain_sel), 2);
    repeat (40) tick(0, 1);
    chk("R9 gain holds at ceiling", int'(gain_sel), 2);

    // R8: thresholds wide open hold the gain
    lo_th = 6'd0; hi_th = 6'd63;
    for (int i = 0; i < 80; i++) begin
      r = $urandom % 4;
      tick(r[0], r[1]);
    end
    chk("R8 hold between thresholds", int'(gain_sel), 2);

    // Random segments
    for (int seg = 0; seg < 40; seg++) begin
      thr_sel = 2'($urandom % 4);
      lo_th = 6'($urandom % 12);
      hi_th = 6'(int'(lo_th) + ($urandom % 24));
      bias = $urandom % 8;
      for (int i = 0; i < 80; i++) begin
        r = $urandom % 8;
        tick(r >= 6, r < bias);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule